// File: doc/BRIEF.md
# Consecutive Training Set Checker

This block watches the stream of decoded TS1/TS2 training ordered sets that reach a link's receiver and reports how many identical sets in a row have arrived. Each set comes with a one-cycle strobe and its symbol fields: set type, link number, lane number, N_FTS, rate identifier and training control. The block compares each new set with the one before it and counts the run, stopping at eight. It also holds the data rates that the link partner advertises, in a register.

Software can remove any of the six symbol fields from the comparison through a per-field mask. This lets a partner that varies a field still build a run. By default the advertised rates are captured only when a run of eight matching sets completes. A mode input makes the block capture the rate field from every set while the link state machine is in Recovery or Configuration. The link state machine pulses a clear input on every state transition, which restarts the run. Alignment and decoding of the ordered sets happen upstream.

Top module: `ts_consec_checker`

## Requirements
- R1: During and after a synchronous reset (`rst` high at a clock edge), `run_cnt_o` is 0, `run_full_o` is 0 and `remote_rate_o` is 0.
- R2: When `run_cnt_o` is 0, an accepted set (`set_vld_i` high, `clr_i` low) makes `run_cnt_o` 1 after that edge and becomes the reference.
- R3: A set whose checked fields all equal those of the reference raises `run_cnt_o` by one, up to a maximum of 8. `run_full_o` is 1 exactly when `run_cnt_o` is 8.
- R4: A set that differs from the reference in any field that is not masked sets `run_cnt_o` to 1. The accepted set always becomes the new reference.
- R5: Mask bit positions in `chk_mask_i`: bit 0 set type (TS1 or TS2), bit 1 link, bit 2 lane, bit 3 N_FTS, bit 4 rate identifier, bit 5 training control. A 1 in a bit excludes that field from the comparison. With bit 0 at 0, a change between TS1 and TS2 is a mismatch.
- R6: With `every_set_i` at 0, `remote_rate_o` takes the rate field of an accepted set at the edge where `run_cnt_o` becomes or stays 8. Otherwise it holds its value.
- R7: With `every_set_i` at 1 and `in_rcfg_i` at 1, every accepted set loads its rate field into `remote_rate_o` at that edge. With `in_rcfg_i` at 0, the rule of R6 applies.
- R8: `clr_i` high sets `run_cnt_o` to 0 and drops the reference, and it leaves `remote_rate_o` unchanged. A set strobed in the same cycle as `clr_i` is discarded.
- R9: In a cycle with neither `set_vld_i` nor `clr_i`, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Clear pulse from the link state machine on each state transition |
| set_vld_i | input | 1 | One-cycle strobe for a decoded training set |
| set_is_ts2_i | input | 1 | Set type: 0 for TS1, 1 for TS2 |
| set_link_i | input | LINK_W | Link number symbol |
| set_lane_i | input | LANE_W | Lane number symbol |
| set_nfts_i | input | NFTS_W | N_FTS symbol |
| set_rate_i | input | RATE_W | Rate identifier symbol |
| set_ctrl_i | input | CTRL_W | Training control symbol |
| chk_mask_i | input | 6 | Per-field comparison disable mask |
| every_set_i | input | 1 | Capture rates from every set in Recovery/Configuration |
| in_rcfg_i | input | 1 | Link state machine is in Recovery or Configuration |
| run_cnt_o | output | CNT_W | Consecutive matching set count, 0 to 8 |
| run_full_o | output | 1 | Run has reached eight |
| remote_rate_o | output | RATE_W | Captured remote data rate vector |

## Verification
On every cycle the assertions check the count's range and its step after an accepted set, the agreement of the full flag with the count, the effect of a clear, and that idle cycles hold all state. They also check that a rate loads in every-set mode and that, in default mode, it changes only at a count of eight. Which field caused a mismatch, how each mask bit works, and the exact rate value taken at the eighth set depend on the set contents. The bench's scenarios show these, using runs built with varied fields, varied masks and switching between modes.

// File: rtl/ts_chk_pkg.sv
package ts_chk_pkg;
  // Field slots in the comparison mask; the order is the mask bit layout.
  typedef enum int {
    FLD_TYPE = 0,
    FLD_LINK = 1,
    FLD_LANE = 2,
    FLD_NFTS = 3,
    FLD_RATE = 4,
    FLD_CTRL = 5
  } ts_field_e;

  localparam int NUM_FIELDS = 6;
  localparam int RUN_TARGET_DEF = 8;
endpackage

// File: rtl/ts_field_cmp.sv
module ts_field_cmp
  import ts_chk_pkg::*;
#(
  parameter int LINK_W = 8,
  parameter int LANE_W = 5,
  parameter int NFTS_W = 8,
  parameter int RATE_W = 8,
  parameter int CTRL_W = 8
) (
  input  logic              cur_ts2,
  input  logic [LINK_W-1:0] cur_link,
  input  logic [LANE_W-1:0] cur_lane,
  input  logic [NFTS_W-1:0] cur_nfts,
  input  logic [RATE_W-1:0] cur_rate,
  input  logic [CTRL_W-1:0] cur_ctrl,
  input  logic              ref_ts2,
  input  logic [LINK_W-1:0] ref_link,
  input  logic [LANE_W-1:0] ref_lane,
  input  logic [NFTS_W-1:0] ref_nfts,
  input  logic [RATE_W-1:0] ref_rate,
  input  logic [CTRL_W-1:0] ref_ctrl,
  input  logic [NUM_FIELDS-1:0] mask,
  output logic              match
);
  logic [NUM_FIELDS-1:0] fld_eq;
  logic [NUM_FIELDS-1:0] fld_ok;

  always_comb begin
    fld_eq           = '0;
    fld_eq[FLD_TYPE] = (cur_ts2  == ref_ts2);
    fld_eq[FLD_LINK] = (cur_link == ref_link);
    fld_eq[FLD_LANE] = (cur_lane == ref_lane);
    fld_eq[FLD_NFTS] = (cur_nfts == ref_nfts);
    fld_eq[FLD_RATE] = (cur_rate == ref_rate);
    fld_eq[FLD_CTRL] = (cur_ctrl == ref_ctrl);
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    assign fld_ok[g] = mask[g] | fld_eq[g];
  end

  assign match = &fld_ok;
endmodule

// File: rtl/ts_run_counter.sv
module ts_run_counter #(
  parameter int RUN_TARGET = 8,
  localparam int CNT_W = $clog2(RUN_TARGET + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             vld,
  input  logic             match,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             reach_nxt
);
  localparam logic [CNT_W-1:0] TGT = CNT_W'(RUN_TARGET);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (clr) begin
      cnt_nxt = '0;
    end else if (vld) begin
      if (cnt == '0 || !match) cnt_nxt = ONE;
      else if (cnt == TGT)     cnt_nxt = TGT;
      else                     cnt_nxt = cnt + ONE;
    end
  end

  assign reach_nxt = vld && !clr && (cnt_nxt == TGT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      full <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      full <= (cnt_nxt == TGT);
    end
  end
endmodule

// File: rtl/ts_rate_capture.sv
module ts_rate_capture #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [RATE_W-1:0] rate_in,
  output logic [RATE_W-1:0] rate_q
);
  always_ff @(posedge clk) begin
    if (rst)      rate_q <= '0;
    else if (cap) rate_q <= rate_in;
  end
endmodule

// File: rtl/ts_consec_checker.sv
module ts_consec_checker
  import ts_chk_pkg::*;
#(
  parameter int LINK_W = 8,
  parameter int LANE_W = 5,
  parameter int NFTS_W = 8,
  parameter int RATE_W = 8,
  parameter int CTRL_W = 8,
  parameter int RUN_TARGET = RUN_TARGET_DEF,
  localparam int CNT_W = $clog2(RUN_TARGET + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              set_vld_i,
  input  logic              set_is_ts2_i,
  input  logic [LINK_W-1:0] set_link_i,
  input  logic [LANE_W-1:0] set_lane_i,
  input  logic [NFTS_W-1:0] set_nfts_i,
  input  logic [RATE_W-1:0] set_rate_i,
  input  logic [CTRL_W-1:0] set_ctrl_i,
  input  logic [NUM_FIELDS-1:0] chk_mask_i,
  input  logic              every_set_i,
  input  logic              in_rcfg_i,
  output logic [CNT_W-1:0]  run_cnt_o,
  output logic              run_full_o,
  output logic [RATE_W-1:0] remote_rate_o
);
  // Reference: the most recently accepted set.
  logic              ref_ts2;
  logic [LINK_W-1:0] ref_link;
  logic [LANE_W-1:0] ref_lane;
  logic [NFTS_W-1:0] ref_nfts;
  logic [RATE_W-1:0] ref_rate;
  logic [CTRL_W-1:0] ref_ctrl;

  logic accept;
  logic match;
  logic reach_nxt;
  logic cap;

  assign accept = set_vld_i && !clr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_ts2  <= 1'b0;
      ref_link <= '0;
      ref_lane <= '0;
      ref_nfts <= '0;
      ref_rate <= '0;
      ref_ctrl <= '0;
    end else if (accept) begin
      ref_ts2  <= set_is_ts2_i;
      ref_link <= set_link_i;
      ref_lane <= set_lane_i;
      ref_nfts <= set_nfts_i;
      ref_rate <= set_rate_i;
      ref_ctrl <= set_ctrl_i;
    end
  end

  ts_field_cmp #(
    .LINK_W(LINK_W), .LANE_W(LANE_W), .NFTS_W(NFTS_W),
    .RATE_W(RATE_W), .CTRL_W(CTRL_W)
  ) u_cmp (
    .cur_ts2 (set_is_ts2_i), .cur_link(set_link_i), .cur_lane(set_lane_i),
    .cur_nfts(set_nfts_i),   .cur_rate(set_rate_i), .cur_ctrl(set_ctrl_i),
    .ref_ts2 (ref_ts2),      .ref_link(ref_link),   .ref_lane(ref_lane),
    .ref_nfts(ref_nfts),     .ref_rate(ref_rate),   .ref_ctrl(ref_ctrl),
    .mask    (chk_mask_i),
    .match   (match)
  );

  ts_run_counter #(.RUN_TARGET(RUN_TARGET)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_i),
    .vld      (set_vld_i),
    .match    (match),
    .cnt      (run_cnt_o),
    .full     (run_full_o),
    .reach_nxt(reach_nxt)
  );

  assign cap = reach_nxt || (accept && every_set_i && in_rcfg_i);

  ts_rate_capture #(.RATE_W(RATE_W)) u_rate (
    .clk    (clk),
    .rst    (rst),
    .cap    (cap),
    .rate_in(set_rate_i),
    .rate_q (remote_rate_o)
  );
endmodule

// File: rtl/ts_consec_checker_sva.sv
module ts_consec_checker_sva #(
  parameter int RATE_W = 8,
  parameter int RUN_TARGET = 8,
  localparam int CNT_W = $clog2(RUN_TARGET + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_i,
  input logic              set_vld_i,
  input logic [RATE_W-1:0] set_rate_i,
  input logic              every_set_i,
  input logic              in_rcfg_i,
  input logic [CNT_W-1:0]  run_cnt_o,
  input logic              run_full_o,
  input logic [RATE_W-1:0] remote_rate_o
);
  localparam logic [CNT_W-1:0] TGT = CNT_W'(RUN_TARGET);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (run_cnt_o == '0 && !run_full_o && remote_rate_o == '0)); // R1

  AST_FIRST_SET: assert property (@(posedge clk) disable iff (rst)
    (set_vld_i && !clr_i && run_cnt_o == '0) |=> run_cnt_o == CNT_W'(1)); // R2

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    run_cnt_o <= TGT); // R3

  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (rst)
    run_full_o == (run_cnt_o == TGT)); // R3

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (set_vld_i && !clr_i && run_cnt_o != '0) |=>
      (run_cnt_o == CNT_W'(1)) ||
      (run_cnt_o == (($past(run_cnt_o) == TGT) ? TGT : $past(run_cnt_o) + CNT_W'(1)))); // R4

  AST_DEFAULT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (set_vld_i && !clr_i && !(every_set_i && in_rcfg_i)) |=>
      (run_cnt_o == TGT) || $stable(remote_rate_o)); // R6

  AST_EVERY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (set_vld_i && !clr_i && every_set_i && in_rcfg_i) |=>
      remote_rate_o == $past(set_rate_i)); // R7

  AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (run_cnt_o == '0 && $stable(remote_rate_o))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!set_vld_i && !clr_i) |=>
      ($stable(run_cnt_o) && $stable(run_full_o) && $stable(remote_rate_o))); // R9
endmodule

bind ts_consec_checker ts_consec_checker_sva #(
  .RATE_W(RATE_W), .RUN_TARGET(RUN_TARGET)
) i_sva (
  .clk          (clk),
  .rst          (rst),
  .clr_i        (clr_i),
  .set_vld_i    (set_vld_i),
  .set_rate_i   (set_rate_i),
  .every_set_i  (every_set_i),
  .in_rcfg_i    (in_rcfg_i),
  .run_cnt_o    (run_cnt_o),
  .run_full_o   (run_full_o),
  .remote_rate_o(remote_rate_o)
);

// File: tb/test_ts_consec_checker.sv
module test_ts_consec_checker;
  localparam int CLK_PERIOD = 10;
  localparam int LINK_W = 8, LANE_W = 5, NFTS_W = 8, RATE_W = 8, CTRL_W = 8;
  localparam int TARGET = 8;
  localparam int CNT_W = $clog2(TARGET + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic vld = 1'b0;
  logic ts2 = 1'b0;
  logic [LINK_W-1:0] link = '0;
  logic [LANE_W-1:0] lane = '0;
  logic [NFTS_W-1:0] nfts = '0;
  logic [RATE_W-1:0] rate = '0;
  logic [CTRL_W-1:0] ctrl = '0;
  logic [5:0] mask = '0;
  logic every = 1'b0;
  logic rcfg = 1'b0;
  logic [CNT_W-1:0]  cnt_o;
  logic              full_o;
  logic [RATE_W-1:0] rate_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_consec_checker i_ts_consec_checker (
    .clk(clk), .rst(rst), .clr_i(clr), .set_vld_i(vld),
    .set_is_ts2_i(ts2), .set_link_i(link), .set_lane_i(lane),
    .set_nfts_i(nfts), .set_rate_i(rate), .set_ctrl_i(ctrl),
    .chk_mask_i(mask), .every_set_i(every), .in_rcfg_i(rcfg),
    .run_cnt_o(cnt_o), .run_full_o(full_o), .remote_rate_o(rate_o)
  );

  typedef struct {
    int    cnt;
    bit    full;
    int    rate;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model state, derived from the requirements.
  int m_cnt = 0;
  int m_rate = 0;
  bit r_ts2; int r_link, r_lane, r_nfts, r_rate, r_ctrl;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input string tag);
    exp_t e;
    e.cnt = m_cnt; e.full = (m_cnt == TARGET); e.rate = m_rate; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Driver: one set per call, driven at the falling edge.
  task automatic send(input bit t2, input int lk, input int ln, input int nf,
                      input int rt, input int ct, input string tag);
    bit same;
    @(negedge clk);
    ts2 = t2; link = LINK_W'(lk); lane = LANE_W'(ln);
    nfts = NFTS_W'(nf); rate = RATE_W'(rt); ctrl = CTRL_W'(ct);
    vld = 1'b1;
    same = (mask[0] || t2 == r_ts2) && (mask[1] || lk == r_link) &&
           (mask[2] || ln == r_lane) && (mask[3] || nf == r_nfts) &&
           (mask[4] || rt == r_rate) && (mask[5] || ct == r_ctrl);
    if (m_cnt == 0 || !same) m_cnt = 1;
    else if (m_cnt < TARGET) m_cnt++;
    r_ts2 = t2; r_link = lk; r_lane = ln; r_nfts = nf; r_rate = rt; r_ctrl = ct;
    if (m_cnt == TARGET || (every && rcfg)) m_rate = rt;
    push(tag);
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic clear(input bit with_set, input string tag);
    @(negedge clk);
    clr = 1'b1;
    vld = with_set;
    rate = 8'hEE;
    m_cnt = 0;
    push(tag);
    @(negedge clk);
    clr = 1'b0;
    vld = 1'b0;
  endtask

  // Monitor: pops one expected item per strobe and compares after the edge.
  initial begin
    forever begin
      @(posedge clk);
      if (!rst && (vld || clr)) begin
        #(CLK_PERIOD/4);
        if (exp_q.size() == 0) begin
          check("QUEUE underflow", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " count"}, int'(cnt_o), e.cnt);
          check({e.tag, " full"}, int'(full_o), int'(e.full));
          check({e.tag, " rate"}, int'(rate_o), e.rate);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 count", int'(cnt_o), 0);
    check("R1 full", int'(full_o), 0);
    check("R1 rate", int'(rate_o), 0);
    rst = 1'b0;

    // R2/R3/R6: ten identical sets; rate captured at the eighth
    for (int i = 0; i < 10; i++) send(0, 3, 1, 20, 8'h06, 0, "R3 R6 identical run");

    // R4: lane differs -> restart at 1, rate held
    send(0, 3, 2, 20, 8'h0E, 0, "R4 lane mismatch");
    send(0, 3, 2, 20, 8'h0E, 0, "R4 after restart");
    send(0, 3, 2, 21, 8'h0E, 0, "R4 nfts mismatch");

    // R5: mask lane (bit 2): varying lanes keep the run going
    mask = 6'b000100;
    for (int i = 0; i < 9; i++) send(0, 3, i, 21, 8'h0E, 0, "R5 lane masked");

    // R5: type change TS1->TS2 unmasked breaks the run
    mask = 6'b000000;
    send(1, 3, 8, 21, 8'h0E, 0, "R5 type mismatch");
    // R5: type masked (bit 0), ctrl masked (bit 5)
    mask = 6'b100001;
    for (int i = 0; i < 4; i++) send(i % 2, 3, 8, 21, 8'h0E, i, "R5 type ctrl masked");

    // R8: clear, then clear with a same-cycle set
    clear(1'b0, "R8 clear");
    send(0, 3, 8, 21, 8'h0E, 0, "R2 first after clear");
    clear(1'b1, "R8 clear beats set");
    mask = 6'b000000;

    // R7: every-set mode in Recovery/Configuration
    every = 1'b1; rcfg = 1'b1;
    send(0, 4, 0, 10, 8'h02, 0, "R7 every set a");
    send(0, 4, 0, 10, 8'h1E, 0, "R7 every set b");
    send(0, 5, 0, 10, 8'h06, 0, "R7 every set c");
    // R7: outside Recovery/Configuration the eight-set rule applies
    rcfg = 1'b0;
    for (int i = 0; i < 8; i++) send(0, 5, 0, 10, 8'h0A, 0, "R7 R6 outside rcfg");
    every = 1'b0;

    // R9: idle cycles hold all outputs
    repeat (4) @(negedge clk);
    check("R9 count", int'(cnt_o), m_cnt);
    check("R9 full", int'(full_o), int'(m_cnt == TARGET));
    check("R9 rate", int'(rate_o), m_rate);

    repeat (3) @(negedge clk);
    check("QUEUE drained", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule